// File: doc/BRIEF.md
# Capture, Compare and PWM Timer Channel

This block is one channel of a multi-channel timer. It watches a shared 16-bit timebase that it does not own: the count value, the modulo limit, a count-advance strobe, a wrap strobe and a timer-reset strobe all arrive as inputs. A control byte selects what the channel does. It can timestamp edges on its pin, which is input capture. It can act on its pin when the count reaches a programmed value, which is output compare. With toggle-on-wrap enabled, output compare becomes an unbuffered pulse-width modulator.

The channel holds one register of the timebase width. Software writes it as a compare value, and a capture overwrites it with the count. Every capture or match raises a channel flag. When enabled, the flag is passed on as either a processor interrupt or a DMA request. When the channel does not own the pin, the pin carries a port-supplied value instead.

Top module: `ccp_channel`

## Requirements
- R1: When the level field (control bits 3:2) is 00, or the mode field (bits 5:4) is 00 (capture), `pin_drive` is 0 and `pin_out` equals `port_val`.
- R2: In capture mode, a level field of 01 captures on rising edges of `pin_in`, 10 captures on falling edges, and 11 captures on both. `pin_in` first passes through a two-flop synchroniser, and an edge of the wrong polarity captures nothing.
- R3: A capture loads the present `tbase_count` into the channel register, readable on `ch_rdata`, and sets the flag (control bit 7).
- R4: In compare mode (any mode field other than 00), a cycle with `tbase_tick` high and `tbase_count` equal to the channel register toggles the output for level 01, clears it for 10 and sets it for 11. The flag sets on every such match. Cycles without `tbase_tick` never match.
- R5: With control bit 1 (toggle-on-wrap) set in compare mode, each cycle with `tbase_tick` and `tbase_wrap` both high inverts the output. In capture mode the bit has no effect on the pin.
- R6: When a wrap toggle and a compare match fall in the same cycle, the output toggles and the compare action is dropped.
- R7: A channel register value greater than `tbase_mod` never matches and never sets the flag.
- R8: Control bit 0 (force-full-duty) is sampled only at a wrap. While the sampled value is 1, the pin holds the timer-reset level. Setting or clearing the bit mid-period changes nothing until the next wrap.
- R9: The flag clears only when a write with bit 7 = 0 follows a control read that saw the flag set. A write without that read leaves the flag set. A capture or match in the same cycle as the clearing write keeps the flag set.
- R10: With interrupt enable (bit 6) set and the flag set, `irq` is driven when `dma_sel` is 0 and `dma_req` when `dma_sel` is 1. With the enable clear, neither is driven.
- R11: `tbase_rst` sets the compare output to the opposite of its action: high for clear, low for set and for toggle.
- R12: After reset, the control byte reads 0 and the channel register reads 0. `ctl_rdata` returns {flag, enable, mode[1:0], level[1:0], toggle-on-wrap, force-full-duty}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tbase_count | input | 16 | Shared timebase count |
| tbase_mod | input | 16 | Timebase modulo limit |
| tbase_tick | input | 1 | Count took a new value this cycle |
| tbase_wrap | input | 1 | The new count is a wrap to zero |
| tbase_rst | input | 1 | Timer reset strobe |
| ctl_wr | input | 1 | Control byte write strobe |
| ctl_rd | input | 1 | Control byte read strobe |
| ctl_wdata | input | 8 | Control write data |
| ctl_rdata | output | 8 | Control byte readback |
| ch_wr | input | 1 | Channel register write strobe |
| ch_wdata | input | 16 | Channel register write data |
| ch_rdata | output | 16 | Channel register readback |
| dma_sel | input | 1 | Route request to DMA (1) or interrupt (0) |
| pin_in | input | 1 | Asynchronous pin level |
| port_val | input | 1 | Port-controlled pin value |
| pin_out | output | 1 | Value presented to the pin |
| pin_drive | output | 1 | Channel owns the pin |
| irq | output | 1 | Interrupt request |
| dma_req | output | 1 | DMA request |

## Verification
Two pairs of functions can land in the same cycle here. A wrap toggle can meet a compare match. A software flag clear can meet a new flag event. The first pair is provoked with a channel value of zero: the output is first cleared by a plain match, and then a tick with wrap high is given at count zero. The test passes only if the pin toggles high rather than being cleared again. The second pair is provoked by arming the clear with a read and then issuing the clearing write in the same cycle as a matching tick; the flag must still read set afterwards.

// File: rtl/ccp_pkg.sv
package ccp_pkg;

  typedef enum logic [1:0] {
    ACT_NONE   = 2'b00,
    ACT_TOGGLE = 2'b01,
    ACT_CLEAR  = 2'b10,
    ACT_SET    = 2'b11
  } act_e;

  typedef struct packed {
    logic       ie;
    logic [1:0] mode;
    act_e       act;
    logic       tov;
    logic       maxd;
  } cfg_t;

  localparam int CFG_W = $bits(cfg_t);

  // Level taken after a timer reset: opposite of the compare action.
  function automatic logic preset_lvl(act_e a);
    return (a == ACT_CLEAR);
  endfunction

endpackage

// File: rtl/ccp_sync.sv
module ccp_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] q;

  genvar i;
  generate
    for (i = 0; i < STAGES; i++) begin : g_stage
      logic d;
      if (i == 0) begin : g_first
        assign d = din;
      end else begin : g_rest
        assign d = q[i-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q[i] <= 1'b0;
        else        q[i] <= d;
      end
    end
  endgenerate

  assign dout = q[STAGES-1];
endmodule

// File: rtl/ccp_capture.sv
module ccp_capture
  import ccp_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  act_e edge_sel,
  input  logic pin_in,
  output logic cap_evt
);
  logic s_q, prev_q, rise, fall;

  ccp_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(pin_in), .dout(s_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= s_q;
  end

  assign rise = s_q & ~prev_q;
  assign fall = ~s_q & prev_q;

  always_comb begin
    case (edge_sel)
      ACT_TOGGLE: cap_evt = enable & rise;
      ACT_CLEAR:  cap_evt = enable & fall;
      ACT_SET:    cap_evt = enable & (rise | fall);
      default:    cap_evt = 1'b0;
    endcase
  end

  // R2: a capture is only ever seen for an edge that was present one stage back
  p_cap_edge_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt |-> (s_q != prev_q));
endmodule

// File: rtl/ccp_compare.sv
module ccp_compare
  import ccp_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cmp_en,
  input  act_e         act,
  input  logic         tov,
  input  logic         max_req,
  input  logic [W-1:0] cnt,
  input  logic [W-1:0] mod_val,
  input  logic         tick,
  input  logic         wrap,
  input  logic         timer_rst,
  input  logic [W-1:0] cmp_val,
  output logic         match,
  output logic         level
);
  logic out_q, out_d, max_q, max_d, ovf, preset;

  assign ovf    = tick & wrap;
  assign preset = preset_lvl(act);
  assign match  = cmp_en & tick & (cnt == cmp_val) & (cmp_val <= mod_val);

  always_comb begin
    out_d = out_q;
    max_d = max_q;
    if (timer_rst) begin
      out_d = preset;
    end else if (cmp_en) begin
      if (ovf && tov) begin
        out_d = ~out_q;
      end else if (match) begin
        case (act)
          ACT_TOGGLE: out_d = ~out_q;
          ACT_CLEAR:  out_d = 1'b0;
          ACT_SET:    out_d = 1'b1;
          default:    out_d = out_q;
        endcase
      end
    end
    if (ovf) max_d = max_req;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= 1'b0;
      max_q <= 1'b0;
    end else begin
      out_q <= out_d;
      max_q <= max_d;
    end
  end

  assign level = max_q ? preset : out_q;

  p_ovf_toggle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && tov && cmp_en && !timer_rst) |=> (out_q == !$past(out_q)));

  p_ovf_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && tov && match && !timer_rst) |=> (out_q != $past(out_q)));

  p_max_period_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !ovf |=> $stable(max_q));

  p_preset_r11: assert property (@(posedge clk) disable iff (!rst_n)
    timer_rst |=> (out_q == $past(act == ACT_CLEAR)));
endmodule

// File: rtl/ccp_flag.sv
module ccp_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic evt,
  input  logic rd_ctl,
  input  logic wr_ctl,
  input  logic wr_flag_bit,
  input  logic ie,
  input  logic dma_sel,
  output logic flag,
  output logic irq,
  output logic dma_req
);
  logic flag_q, flag_d, armed_q, armed_d;

  always_comb begin
    flag_d  = flag_q;
    armed_d = armed_q;
    if (evt)                                     flag_d = 1'b1;
    else if (wr_ctl && !wr_flag_bit && armed_q)  flag_d = 1'b0;
    if (wr_ctl)                 armed_d = 1'b0;
    else if (rd_ctl && flag_q)  armed_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q  <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      flag_q  <= flag_d;
      armed_q <= armed_d;
    end
  end

  assign flag    = flag_q;
  assign irq     = flag_q & ie & ~dma_sel;
  assign dma_req = flag_q & ie & dma_sel;

  p_evt_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
    evt |=> flag_q);

  p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctl && !wr_flag_bit && armed_q && !evt) |=> !flag_q);

  p_noclear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !armed_q) |=> flag_q);
endmodule

// File: rtl/ccp_channel.sv
module ccp_channel
  import ccp_pkg::*;
#(
  parameter int W           = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] tbase_count,
  input  logic [W-1:0] tbase_mod,
  input  logic         tbase_tick,
  input  logic         tbase_wrap,
  input  logic         tbase_rst,
  input  logic         ctl_wr,
  input  logic         ctl_rd,
  input  logic [7:0]   ctl_wdata,
  output logic [7:0]   ctl_rdata,
  input  logic         ch_wr,
  input  logic [W-1:0] ch_wdata,
  output logic [W-1:0] ch_rdata,
  input  logic         dma_sel,
  input  logic         pin_in,
  input  logic         port_val,
  output logic         pin_out,
  output logic         pin_drive,
  output logic         irq,
  output logic         dma_req
);
  cfg_t         cfg_q, cfg_d;
  logic [W-1:0] chreg_q, chreg_d;
  logic         cap_mode, cmp_mode, cap_evt, match, level, flag;

  assign cap_mode = (cfg_q.mode == 2'b00);
  assign cmp_mode = ~cap_mode;

  always_comb begin
    cfg_d = cfg_q;
    if (ctl_wr) cfg_d = cfg_t'(ctl_wdata[CFG_W-1:0]);
  end

  always_comb begin
    chreg_d = chreg_q;
    if (cap_evt)    chreg_d = tbase_count;
    else if (ch_wr) chreg_d = ch_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q   <= '0;
      chreg_q <= '0;
    end else begin
      cfg_q   <= cfg_d;
      chreg_q <= chreg_d;
    end
  end

  ccp_capture #(.SYNC_STAGES(SYNC_STAGES)) u_cap (
    .clk(clk), .rst_n(rst_n), .enable(cap_mode), .edge_sel(cfg_q.act),
    .pin_in(pin_in), .cap_evt(cap_evt)
  );

  ccp_compare #(.W(W)) u_cmp (
    .clk(clk), .rst_n(rst_n), .cmp_en(cmp_mode), .act(cfg_q.act),
    .tov(cfg_q.tov), .max_req(cfg_q.maxd), .cnt(tbase_count),
    .mod_val(tbase_mod), .tick(tbase_tick), .wrap(tbase_wrap),
    .timer_rst(tbase_rst), .cmp_val(chreg_q), .match(match), .level(level)
  );

  ccp_flag u_flag (
    .clk(clk), .rst_n(rst_n), .evt(cap_evt | match), .rd_ctl(ctl_rd),
    .wr_ctl(ctl_wr), .wr_flag_bit(ctl_wdata[7]), .ie(cfg_q.ie),
    .dma_sel(dma_sel), .flag(flag), .irq(irq), .dma_req(dma_req)
  );

  assign pin_drive = cmp_mode & (cfg_q.act != ACT_NONE);
  assign pin_out   = pin_drive ? level : port_val;
  assign ctl_rdata = {flag, cfg_q};
  assign ch_rdata  = chreg_q;

  p_cap_latch_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt |=> (ch_rdata == $past(tbase_count)));

  p_no_match_above_mod_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_mode && tbase_tick && (chreg_q > tbase_mod) && !ctl_wr && !ctl_rd && !cap_evt && !flag)
      |=> !ctl_rdata[7]);
endmodule

// File: tb/tb_ccp_channel.sv
module tb_ccp_channel;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] tbase_count, tbase_mod, ch_wdata, ch_rdata;
  logic        tbase_tick, tbase_wrap, tbase_rst, ctl_wr, ctl_rd, ch_wr;
  logic [7:0]  ctl_wdata, ctl_rdata;
  logic        dma_sel, pin_in, port_val, pin_out, pin_drive, irq, dma_req;
  int          n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  ccp_channel dut (
    .clk(clk), .rst_n(rst_n), .tbase_count(tbase_count), .tbase_mod(tbase_mod),
    .tbase_tick(tbase_tick), .tbase_wrap(tbase_wrap), .tbase_rst(tbase_rst),
    .ctl_wr(ctl_wr), .ctl_rd(ctl_rd), .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata),
    .ch_wr(ch_wr), .ch_wdata(ch_wdata), .ch_rdata(ch_rdata), .dma_sel(dma_sel),
    .pin_in(pin_in), .port_val(port_val), .pin_out(pin_out), .pin_drive(pin_drive),
    .irq(irq), .dma_req(dma_req)
  );

  // {ctl[7:0], count[15:0], tick, wrap, exp pin, exp flag}; channel value 0x0040
  localparam logic [27:0] VEC [12] = '{
    {8'h1A, 16'h0010, 1'b1, 1'b0, 1'b1, 1'b0},  // R4 no match
    {8'h1A, 16'h0040, 1'b1, 1'b0, 1'b0, 1'b1},  // R4 clear
    {8'h1A, 16'h0000, 1'b1, 1'b1, 1'b1, 1'b1},  // R5 wrap toggle
    {8'h1A, 16'h0040, 1'b1, 1'b0, 1'b0, 1'b1},  // R4 clear
    {8'h16, 16'h0040, 1'b1, 1'b0, 1'b1, 1'b1},  // R4 toggle
    {8'h16, 16'h0040, 1'b1, 1'b0, 1'b0, 1'b1},  // R4 toggle
    {8'h1C, 16'h0040, 1'b1, 1'b0, 1'b1, 1'b1},  // R4 set
    {8'h1C, 16'h0000, 1'b1, 1'b1, 1'b1, 1'b1},  // R5 no toggle when bit clear
    {8'h18, 16'h0040, 1'b1, 1'b0, 1'b0, 1'b1},  // R4 clear
    {8'h18, 16'h0000, 1'b1, 1'b1, 1'b0, 1'b1},  // R5 no toggle
    {8'h10, 16'h0040, 1'b1, 1'b0, 1'b1, 1'b1},  // R1 port value
    {8'h1C, 16'h0040, 1'b0, 1'b0, 1'b0, 1'b1}   // R4 no tick, no action
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr_ctl(input logic [7:0] d);
    @(negedge clk); ctl_wr = 1'b1; ctl_wdata = d;
    @(negedge clk); ctl_wr = 1'b0;
  endtask

  task automatic rd_ctl();
    @(negedge clk); ctl_rd = 1'b1;
    @(negedge clk); ctl_rd = 1'b0;
  endtask

  task automatic wr_ch(input logic [15:0] d);
    @(negedge clk); ch_wr = 1'b1; ch_wdata = d;
    @(negedge clk); ch_wr = 1'b0;
  endtask

  task automatic tmr_rst();
    @(negedge clk); tbase_rst = 1'b1;
    @(negedge clk); tbase_rst = 1'b0;
  endtask

  task automatic step(input logic [15:0] c, input logic t, input logic w);
    @(negedge clk); tbase_count = c; tbase_tick = t; tbase_wrap = w;
    @(negedge clk); tbase_tick = 1'b0; tbase_wrap = 1'b0;
  endtask

  task automatic settle(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  initial begin
    #(20 * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; tbase_count = '0; tbase_mod = 16'h00FF; tbase_tick = 1'b0;
    tbase_wrap = 1'b0; tbase_rst = 1'b0; ctl_wr = 1'b0; ctl_rd = 1'b0;
    ctl_wdata = '0; ch_wr = 1'b0; ch_wdata = '0; dma_sel = 1'b0;
    pin_in = 1'b0; port_val = 1'b1;
    settle(3);
    rst_n = 1'b1;
    settle(1);

    // R12 reset state
    check("R12 ctl reset", ctl_rdata, 8'h00);
    check("R12 chreg reset", ch_rdata, 16'h0000);
    check("R10 no request at reset", {irq, dma_req}, 2'b00);
    check("R1 not driving at reset", pin_drive, 1'b0);

    wr_ch(16'h0040);
    wr_ctl(8'h1A);
    tmr_rst();
    check("R11 clear action presets high", pin_out, 1'b1);

    for (int i = 0; i < 12; i++) begin
      wr_ctl(VEC[i][27:20]);
      step(VEC[i][19:4], VEC[i][3], VEC[i][2]);
      check($sformatf("R4 vector %0d pin", i), pin_out, VEC[i][1]);
      check($sformatf("R4 vector %0d flag", i), ctl_rdata[7], VEC[i][0]);
    end

    // R9 write without a prior read leaves the flag
    wr_ctl(8'h18);
    check("R9 write without read", ctl_rdata[7], 1'b1);
    rd_ctl();
    wr_ctl(8'h18);
    check("R9 read then write clears", ctl_rdata, 8'h18);

    // R9 event in the same cycle as the clearing write
    step(16'h0040, 1'b1, 1'b0);
    rd_ctl();
    @(negedge clk); ctl_wr = 1'b1; ctl_wdata = 8'h18;
    tbase_count = 16'h0040; tbase_tick = 1'b1;
    @(negedge clk); ctl_wr = 1'b0; tbase_tick = 1'b0;
    check("R9 event beats clear", ctl_rdata[7], 1'b1);

    // R10 routing
    wr_ctl(8'h58);
    dma_sel = 1'b0; settle(1);
    check("R10 cpu route", {irq, dma_req}, 2'b10);
    dma_sel = 1'b1; settle(1);
    check("R10 dma route", {irq, dma_req}, 2'b01);
    wr_ctl(8'h18);
    check("R10 enable gates", {irq, dma_req}, 2'b00);
    dma_sel = 1'b0;

    // R7 compare beyond modulo
    rd_ctl();
    wr_ctl(8'h1C);
    tbase_mod = 16'h0030;
    step(16'h0040, 1'b1, 1'b0);
    check("R7 no match above modulo flag", ctl_rdata[7], 1'b0);
    check("R7 no match above modulo pin", pin_out, 1'b0);
    tbase_mod = 16'h00FF;
    step(16'h0040, 1'b1, 1'b0);
    check("R7 match within modulo", {pin_out, ctl_rdata[7]}, 2'b11);

    // R6 wrap toggle beats a same-cycle clear
    wr_ch(16'h0000);
    wr_ctl(8'h1A);
    tmr_rst();
    step(16'h0000, 1'b1, 1'b0);
    check("R6 plain clear", pin_out, 1'b0);
    step(16'h0000, 1'b1, 1'b1);
    check("R6 overflow wins", pin_out, 1'b1);

    // R11 other presets
    wr_ctl(8'h1E); tmr_rst();
    check("R11 set action presets low", pin_out, 1'b0);
    wr_ctl(8'h16); tmr_rst();
    check("R11 toggle action presets low", pin_out, 1'b0);

    // R8 force-full-duty takes effect at the next wrap
    wr_ch(16'h0040);
    wr_ctl(8'h1A); tmr_rst();
    wr_ctl(8'h1B);
    step(16'h0040, 1'b1, 1'b0);
    check("R8 not yet forced", pin_out, 1'b0);
    step(16'h0000, 1'b1, 1'b1);
    step(16'h0040, 1'b1, 1'b0);
    check("R8 forced after wrap", pin_out, 1'b1);
    wr_ctl(8'h1A);
    step(16'h0040, 1'b1, 1'b0);
    check("R8 still forced until wrap", pin_out, 1'b1);
    step(16'h0000, 1'b1, 1'b1);
    step(16'h0040, 1'b1, 1'b0);
    check("R8 released after wrap", pin_out, 1'b0);

    // R2 R3 capture
    rd_ctl();
    wr_ctl(8'h04);
    check("R1 capture mode not driving", {pin_drive, pin_out}, 2'b01);
    tbase_count = 16'h1234;
    pin_in = 1'b1; settle(5);
    check("R3 rising capture flag", ctl_rdata[7], 1'b1);
    check("R3 rising capture value", ch_rdata, 16'h1234);
    rd_ctl(); wr_ctl(8'h04);
    tbase_count = 16'h2222;
    pin_in = 1'b0; settle(5);
    check("R2 falling ignored in rising mode", {ctl_rdata[7], ch_rdata}, {1'b0, 16'h1234});
    wr_ctl(8'h08);
    pin_in = 1'b1; settle(5);
    check("R2 rising ignored in falling mode", ctl_rdata[7], 1'b0);
    tbase_count = 16'h3333;
    pin_in = 1'b0; settle(5);
    check("R2 falling capture", {ctl_rdata[7], ch_rdata}, {1'b1, 16'h3333});
    rd_ctl(); wr_ctl(8'h0C);
    tbase_count = 16'h4444;
    pin_in = 1'b1; settle(5);
    check("R2 any-edge capture", {ctl_rdata[7], ch_rdata}, {1'b1, 16'h4444});

    // R5 toggle-on-wrap inert in capture mode
    wr_ctl(8'h06);
    port_val = 1'b0;
    step(16'h0000, 1'b1, 1'b1);
    check("R5 capture mode ignores wrap toggle", {pin_drive, pin_out}, 2'b00);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule